// File: doc/BRIEF.md
# Integer Execution Unit with Compare, Shift and Multiply

This block is the purely combinational integer datapath of a 32-bit core. It receives a fetched instruction word together with the values read from the two source registers it names, and in the same cycle it presents a 32-bit result, the index of the register to write, and a write enable. Both instruction layouts are handled: the immediate layout, whose low 16-bit constant is widened in one of three ways, and the register layout, which selects its operation through a 6-bit function field.

The supported work covers addition and subtraction, bitwise logic including NOR, compares that yield 1 or 0, shifts by a register or by a 5-bit constant, left and right rotates, and multiplication. Multiplication returns either the low word of the product or the high word in one of three signedness flavours. Any encoding outside this set raises no write. Source index 0 is always seen as the value zero, and a result aimed at index 0 is discarded. The surrounding pipeline keeps the register file, the program counter, memory access and control-register traffic.

Top module: `alu_int_exec`

## Requirements
- R1: The opcode sits in instruction bits [5:0]; opcode 0x3A selects the register layout, whose function code is in bits [16:11] and whose destination is bits [21:17]; every other opcode uses the immediate layout, with the destination in bits [26:22] and the 16-bit constant in bits [21:6].
- R2: The first source index is bits [31:27] and the second is bits [26:22]; when an index is 0, its operand is taken as zero whatever value the port carries.
- R3: When the destination index is 0, write enable stays low.
- R4: Function codes outside the listed set (for example 0x24) and opcodes outside the listed set (for example 0x00) leave write enable low.
- R5: In the register layout, 0x31 adds, 0x39 subtracts (A minus B), 0x0E ANDs, 0x16 ORs, 0x1E XORs and 0x06 gives NOR, all modulo 2^32.
- R6: The add-immediate opcode 0x04 and the multiply-immediate opcode 0x24 sign-extend the constant to 32 bits.
- R7: The immediate logic opcodes 0x0C (AND), 0x14 (OR) and 0x1C (XOR) zero-extend the constant; 0x2C, 0x34 and 0x3C apply the same operations with the constant placed in bits [31:16] and zeros below.
- R8: Compares write 1 when true and 0 when false. The register codes are signed >= 0x08, signed < 0x10, != 0x18, == 0x20, unsigned >= 0x28 and unsigned < 0x30. The immediate opcodes are signed >= 0x08, signed < 0x10, != 0x18 and == 0x20, which use the sign-extended constant, and unsigned >= 0x28 and unsigned < 0x30, which use the zero-extended constant.
- R9: Shift left is 0x12 (amount in bits [10:6]) and 0x13 (amount from B); logical right is 0x1A and 0x1B; arithmetic right is 0x3A and 0x3B. A register amount uses only the low 5 bits of B.
- R10: Rotate left is 0x02 (amount in bits [10:6]) and 0x03 (amount from the low 5 bits of B); rotate right is 0x0B, with the amount from the low 5 bits of B. A rotate by 0 returns A unchanged.
- R11: Function 0x27 returns the low 32 bits of A times B.
- R12: The high-word multiplies return bits [63:32] of the 64-bit product: 0x07 treats both operands as unsigned, 0x1F treats both as signed, and 0x17 treats A as signed and B as unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| opa | input | 32 | Value read for the first source index |
| opb | input | 32 | Value read for the second source index |
| result | output | 32 | Computed value; zero when the encoding is not recognised |
| dst | output | 5 | Destination register index taken from the instruction |
| wr_en | output | 1 | High when the result should be written back |

## Verification
The hardest outcomes to observe are the high-word multiplies. Their three flavours agree on small positive operands and only part ways when the operand sign bits are set, so the stimulus drives all-ones and most-negative operands, where the unsigned, signed and mixed answers all differ. Rotates are swept over every amount from 0 to 31 against a rotation the bench computes itself, so the wrap-around at amount 0 and the carry-in of high bits are both covered. Port values that should be masked by index 0, and register amounts with bits above bit 4 set, are driven on purpose to show that those values are ignored.

// File: rtl/alu_int_pkg.sv
package alu_int_pkg;

   localparam int unsigned OPC_W  = 6;
   localparam int unsigned IDX_W  = 5;
   localparam int unsigned IMM_W  = 16;

   localparam logic [OPC_W-1:0] OPC_RFMT = 6'h3A;

   // immediate-layout opcodes
   localparam logic [OPC_W-1:0] IO_ADD   = 6'h04;
   localparam logic [OPC_W-1:0] IO_MUL   = 6'h24;
   localparam logic [OPC_W-1:0] IO_AND   = 6'h0C;
   localparam logic [OPC_W-1:0] IO_OR    = 6'h14;
   localparam logic [OPC_W-1:0] IO_XOR   = 6'h1C;
   localparam logic [OPC_W-1:0] IO_ANDH  = 6'h2C;
   localparam logic [OPC_W-1:0] IO_ORH   = 6'h34;
   localparam logic [OPC_W-1:0] IO_XORH  = 6'h3C;
   localparam logic [OPC_W-1:0] IO_GE    = 6'h08;
   localparam logic [OPC_W-1:0] IO_LT    = 6'h10;
   localparam logic [OPC_W-1:0] IO_NE    = 6'h18;
   localparam logic [OPC_W-1:0] IO_EQ    = 6'h20;
   localparam logic [OPC_W-1:0] IO_GEU   = 6'h28;
   localparam logic [OPC_W-1:0] IO_LTU   = 6'h30;

   // register-layout function codes
   localparam logic [OPC_W-1:0] FN_ADD   = 6'h31;
   localparam logic [OPC_W-1:0] FN_SUB   = 6'h39;
   localparam logic [OPC_W-1:0] FN_AND   = 6'h0E;
   localparam logic [OPC_W-1:0] FN_OR    = 6'h16;
   localparam logic [OPC_W-1:0] FN_XOR   = 6'h1E;
   localparam logic [OPC_W-1:0] FN_NOR   = 6'h06;
   localparam logic [OPC_W-1:0] FN_GE    = 6'h08;
   localparam logic [OPC_W-1:0] FN_LT    = 6'h10;
   localparam logic [OPC_W-1:0] FN_NE    = 6'h18;
   localparam logic [OPC_W-1:0] FN_EQ    = 6'h20;
   localparam logic [OPC_W-1:0] FN_GEU   = 6'h28;
   localparam logic [OPC_W-1:0] FN_LTU   = 6'h30;
   localparam logic [OPC_W-1:0] FN_MUL   = 6'h27;
   localparam logic [OPC_W-1:0] FN_MULUU = 6'h07;
   localparam logic [OPC_W-1:0] FN_MULSS = 6'h1F;
   localparam logic [OPC_W-1:0] FN_MULSU = 6'h17;
   localparam logic [OPC_W-1:0] FN_SLLI  = 6'h12;
   localparam logic [OPC_W-1:0] FN_SLL   = 6'h13;
   localparam logic [OPC_W-1:0] FN_SRLI  = 6'h1A;
   localparam logic [OPC_W-1:0] FN_SRL   = 6'h1B;
   localparam logic [OPC_W-1:0] FN_SRAI  = 6'h3A;
   localparam logic [OPC_W-1:0] FN_SRA   = 6'h3B;
   localparam logic [OPC_W-1:0] FN_ROLI  = 6'h02;
   localparam logic [OPC_W-1:0] FN_ROL   = 6'h03;
   localparam logic [OPC_W-1:0] FN_ROR   = 6'h0B;

   typedef enum logic [4:0] {
      K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
      K_CGE, K_CLT, K_CNE, K_CEQ, K_CGEU, K_CLTU,
      K_SLL, K_SRL, K_SRA, K_ROL, K_ROR,
      K_MUL, K_MULUU, K_MULSS, K_MULSU
   } alu_kind_e;

endpackage

// File: rtl/alu_int_decode.sv
module alu_int_decode
   import alu_int_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [26:0]         instr_lo,
   output alu_kind_e           kind,
   output logic [IDX_W-1:0]    dst,
   output logic                use_imm,
   output logic                amt_imm,
   output logic [DATA_W-1:0]   imm_val
);
   localparam int unsigned PAD_W = DATA_W - IMM_W;

   logic [OPC_W-1:0] opc;
   logic [OPC_W-1:0] fn;
   logic [IMM_W-1:0] imm;
   logic             rfmt;
   logic [DATA_W-1:0] imm_sx, imm_zx, imm_hi;

   assign opc    = instr_lo[5:0];
   assign fn     = instr_lo[16:11];
   assign imm    = instr_lo[21:6];
   assign rfmt   = (opc == OPC_RFMT);
   assign dst    = rfmt ? instr_lo[21:17] : instr_lo[26:22];
   assign imm_sx = {{PAD_W{imm[IMM_W-1]}}, imm};
   assign imm_zx = {{PAD_W{1'b0}}, imm};
   assign imm_hi = {imm, {PAD_W{1'b0}}};

   always_comb begin
      kind    = K_NONE;
      use_imm = !rfmt;
      amt_imm = 1'b0;
      imm_val = imm_sx;
      if (rfmt) begin
         case (fn)
            FN_ADD:   kind = K_ADD;
            FN_SUB:   kind = K_SUB;
            FN_AND:   kind = K_AND;
            FN_OR:    kind = K_OR;
            FN_XOR:   kind = K_XOR;
            FN_NOR:   kind = K_NOR;
            FN_GE:    kind = K_CGE;
            FN_LT:    kind = K_CLT;
            FN_NE:    kind = K_CNE;
            FN_EQ:    kind = K_CEQ;
            FN_GEU:   kind = K_CGEU;
            FN_LTU:   kind = K_CLTU;
            FN_MUL:   kind = K_MUL;
            FN_MULUU: kind = K_MULUU;
            FN_MULSS: kind = K_MULSS;
            FN_MULSU: kind = K_MULSU;
            FN_SLL:   kind = K_SLL;
            FN_SRL:   kind = K_SRL;
            FN_SRA:   kind = K_SRA;
            FN_ROL:   kind = K_ROL;
            FN_ROR:   kind = K_ROR;
            FN_SLLI:  begin kind = K_SLL; amt_imm = 1'b1; end
            FN_SRLI:  begin kind = K_SRL; amt_imm = 1'b1; end
            FN_SRAI:  begin kind = K_SRA; amt_imm = 1'b1; end
            FN_ROLI:  begin kind = K_ROL; amt_imm = 1'b1; end
            default:  kind = K_NONE;
         endcase
      end else begin
         case (opc)
            IO_ADD:  kind = K_ADD;
            IO_MUL:  kind = K_MUL;
            IO_GE:   kind = K_CGE;
            IO_LT:   kind = K_CLT;
            IO_NE:   kind = K_CNE;
            IO_EQ:   kind = K_CEQ;
            IO_AND:  begin kind = K_AND;  imm_val = imm_zx; end
            IO_OR:   begin kind = K_OR;   imm_val = imm_zx; end
            IO_XOR:  begin kind = K_XOR;  imm_val = imm_zx; end
            IO_GEU:  begin kind = K_CGEU; imm_val = imm_zx; end
            IO_LTU:  begin kind = K_CLTU; imm_val = imm_zx; end
            IO_ANDH: begin kind = K_AND;  imm_val = imm_hi; end
            IO_ORH:  begin kind = K_OR;   imm_val = imm_hi; end
            IO_XORH: begin kind = K_XOR;  imm_val = imm_hi; end
            default: kind = K_NONE;
         endcase
      end
   end
endmodule

// File: rtl/alu_int_shift.sv
module alu_int_shift
   import alu_int_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned SH_W = $clog2(DATA_W)
) (
   input  alu_kind_e           kind,
   input  logic [DATA_W-1:0]   a,
   input  logic [SH_W-1:0]     amt,
   output logic [DATA_W-1:0]   y
);
   logic [2*DATA_W-1:0] dbl, rl, rr;

   assign dbl = {a, a};
   assign rl  = dbl << amt;
   assign rr  = dbl >> amt;

   always_comb begin
      case (kind)
         K_SLL:   y = a << amt;
         K_SRL:   y = a >> amt;
         K_SRA:   y = DATA_W'($signed(a) >>> amt);
         K_ROL:   y = rl[2*DATA_W-1:DATA_W];
         K_ROR:   y = rr[DATA_W-1:0];
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/alu_int_mul.sv
module alu_int_mul #(
   parameter int unsigned DATA_W = 32,
   parameter bit          SHARED = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              a_signed,
   input  logic              b_signed,
   output logic [DATA_W-1:0] lo,
   output logic [DATA_W-1:0] hi
);
   localparam int unsigned PW = 2 * DATA_W;

   generate
      if (SHARED) begin : g_shared
         // one widened signed product serves every flavour
         logic signed [DATA_W:0]   ea, eb;
         logic signed [PW+1:0]     prod;
         assign ea   = {a_signed & a[DATA_W-1], a};
         assign eb   = {b_signed & b[DATA_W-1], b};
         assign prod = ea * eb;
         assign lo   = prod[DATA_W-1:0];
         assign hi   = prod[PW-1:DATA_W];
      end else begin : g_split
         // separate products chosen by the signedness flags
         logic [PW-1:0] p_uu, p_ss, p_su;
         logic [PW-1:0] a_sx, b_zx;
         assign a_sx = {{DATA_W{a[DATA_W-1]}}, a};
         assign b_zx = {{DATA_W{1'b0}}, b};
         assign p_uu = {{DATA_W{1'b0}}, a} * b_zx;
         assign p_ss = PW'($signed(a) * $signed(b));
         assign p_su = a_sx * b_zx;
         assign lo   = p_uu[DATA_W-1:0];
         always_comb begin
            if (a_signed && b_signed) hi = p_ss[PW-1:DATA_W];
            else if (a_signed)        hi = p_su[PW-1:DATA_W];
            else                      hi = p_uu[PW-1:DATA_W];
         end
      end
   endgenerate
endmodule

// File: rtl/alu_int_exec.sv
module alu_int_exec
   import alu_int_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter bit          MUL_SHARED = 1'b1,
   localparam int unsigned SH_W      = $clog2(DATA_W)
) (
   input  logic [31:0]        instr,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   output logic [DATA_W-1:0]  result,
   output logic [IDX_W-1:0]   dst,
   output logic               wr_en
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("alu_int_exec: the encoding fixes DATA_W at 32");
      end
   endgenerate

   alu_kind_e         kind;
   logic              use_imm, amt_imm;
   logic [DATA_W-1:0] imm_val, a, bsrc, b;
   logic [DATA_W-1:0] sh_y, mul_lo, mul_hi;
   logic [SH_W-1:0]   amt;
   logic              a_sgn, b_sgn, eq, lts, ltu;

   alu_int_decode #(.DATA_W(DATA_W)) u_dec (
      .instr_lo (instr[26:0]),
      .kind     (kind),
      .dst      (dst),
      .use_imm  (use_imm),
      .amt_imm  (amt_imm),
      .imm_val  (imm_val)
   );

   // index 0 reads as zero
   assign a    = (instr[31:27] == '0) ? '0 : opa;
   assign bsrc = (instr[26:22] == '0) ? '0 : opb;
   assign b    = use_imm ? imm_val : bsrc;
   assign amt  = amt_imm ? instr[6 +: SH_W] : b[SH_W-1:0];

   alu_int_shift #(.DATA_W(DATA_W)) u_sh (
      .kind (kind),
      .a    (a),
      .amt  (amt),
      .y    (sh_y)
   );

   assign a_sgn = (kind == K_MULSS) || (kind == K_MULSU);
   assign b_sgn = (kind == K_MULSS);

   alu_int_mul #(.DATA_W(DATA_W), .SHARED(MUL_SHARED)) u_mul (
      .a        (a),
      .b        (b),
      .a_signed (a_sgn),
      .b_signed (b_sgn),
      .lo       (mul_lo),
      .hi       (mul_hi)
   );

   assign eq  = (a == b);
   assign lts = ($signed(a) < $signed(b));
   assign ltu = (a < b);

   always_comb begin
      case (kind)
         K_ADD:   result = a + b;
         K_SUB:   result = a - b;
         K_AND:   result = a & b;
         K_OR:    result = a | b;
         K_XOR:   result = a ^ b;
         K_NOR:   result = ~(a | b);
         K_CGE:   result = DATA_W'(!lts);
         K_CLT:   result = DATA_W'(lts);
         K_CNE:   result = DATA_W'(!eq);
         K_CEQ:   result = DATA_W'(eq);
         K_CGEU:  result = DATA_W'(!ltu);
         K_CLTU:  result = DATA_W'(ltu);
         K_SLL, K_SRL, K_SRA, K_ROL, K_ROR: result = sh_y;
         K_MUL:   result = mul_lo;
         K_MULUU, K_MULSS, K_MULSU: result = mul_hi;
         default: result = '0;
      endcase
   end

   assign wr_en = (kind != K_NONE) && (dst != '0);
endmodule

// File: rtl/alu_int_exec_chk.sv
module alu_int_exec_chk (
   input logic [31:0] instr,
   input logic [31:0] opa,
   input logic [31:0] opb,
   input logic [31:0] result,
   input logic [4:0]  dst,
   input logic        wr_en
);
   logic        rfmt;
   logic [5:0]  fn;
   logic [31:0] av, bv;

   assign rfmt = (instr[5:0] == 6'h3A);
   assign fn   = instr[16:11];
   assign av   = (instr[31:27] == 5'd0) ? 32'd0 : opa;
   assign bv   = (instr[26:22] == 5'd0) ? 32'd0 : opb;

   always_comb begin
      AST_DST_FIELD: assert (!wr_en || dst == (rfmt ? instr[21:17] : instr[26:22]))
         else $error("destination field mismatch"); // R1
      AST_ZERO_DST_HELD: assert (!(wr_en && dst == 5'd0))
         else $error("write aimed at index 0"); // R3
      AST_UNKNOWN_FN_HELD: assert (!(rfmt && fn == 6'h24) || !wr_en)
         else $error("unknown function wrote"); // R4
      AST_ADD_SUM: assert (!(rfmt && fn == 6'h31 && wr_en) || result == av + bv)
         else $error("register add mismatch"); // R5
      AST_CMP_BOOL: assert (!(rfmt && wr_en && (fn == 6'h08 || fn == 6'h10 || fn == 6'h18 ||
                                              fn == 6'h20 || fn == 6'h28 || fn == 6'h30))
                            || result[31:1] == 31'd0)
         else $error("compare not 0 or 1"); // R8
      AST_ROL_ZERO: assert (!(rfmt && fn == 6'h02 && instr[10:6] == 5'd0 && wr_en) || result == av)
         else $error("rotate by zero altered operand"); // R10
   end
endmodule

bind alu_int_exec alu_int_exec_chk u_chk (.*);

// File: tb/alu_int_exec_test.sv
module alu_int_exec_test;

   typedef struct packed {
      logic [31:0] ins;
      logic [31:0] a;
      logic [31:0] b;
      logic        wr;
      logic [4:0]  dst;
      logic        chk;
      logic [31:0] res;
      logic [7:0]  req;
   } vec_t;

   function automatic logic [31:0] rt(input logic [5:0] fn, input logic [4:0] ra,
                                      input logic [4:0] rb, input logic [4:0] rc,
                                      input logic [4:0] i5);
      return {ra, rb, rc, fn, i5, 6'h3A};
   endfunction

   function automatic logic [31:0] it(input logic [5:0] op, input logic [4:0] ra,
                                      input logic [4:0] rb, input logic [15:0] imm);
      return {ra, rb, imm, op};
   endfunction

   function automatic vec_t mk(input logic [31:0] ins, input logic [31:0] a,
                               input logic [31:0] b, input logic wr, input logic [4:0] d,
                               input logic chk, input logic [31:0] res, input logic [7:0] req);
      return '{ins: ins, a: a, b: b, wr: wr, dst: d, chk: chk, res: res, req: req};
   endfunction

   localparam int NV = 31;
   localparam vec_t VEC [NV] = '{
      mk(rt(6'h31,1,2,17,0), 32'd5,         32'd7,         1,17,1,32'd12,        5), // R5 add, R1 field
      mk(rt(6'h39,1,2,3,0),  32'd5,         32'd7,         1,3, 1,32'hFFFFFFFE,  5), // R5 sub
      mk(rt(6'h06,1,2,3,0),  32'hF0F00000,  32'h000000FF,  1,3, 1,32'h0F0FFF00,  5), // R5 nor
      mk(rt(6'h16,1,2,3,0),  32'h00001200,  32'h00000034,  1,3, 1,32'h00001234,  5), // R5 or
      mk(it(6'h04,1,22,16'hFFFF), 32'd0,    32'd99,        1,22,1,32'hFFFFFFFF,  6), // R6 addi, R1 field
      mk(it(6'h24,1,2,16'hFFFE),  32'd3,    32'd0,         1,2, 1,32'hFFFFFFFA,  6), // R6 muli
      mk(it(6'h0C,1,2,16'h8001),  32'hFFFFFFFF, 32'd0,     1,2, 1,32'h00008001,  7), // R7 andi
      mk(it(6'h34,1,2,16'hABCD),  32'h00000001, 32'd0,     1,2, 1,32'hABCD0001,  7), // R7 orhi
      mk(it(6'h3C,1,2,16'h8000),  32'h80000000, 32'd0,     1,2, 1,32'h00000000,  7), // R7 xorhi
      mk(rt(6'h10,1,2,3,0),  32'hFFFFFFFF,  32'd1,         1,3, 1,32'd1,         8), // R8 signed lt
      mk(rt(6'h30,1,2,3,0),  32'hFFFFFFFF,  32'd1,         1,3, 1,32'd0,         8), // R8 unsigned lt
      mk(it(6'h08,1,2,16'hFFFF),  32'd0,    32'd0,         1,2, 1,32'd1,         8), // R8 gei
      mk(it(6'h28,1,2,16'hFFFF),  32'd0,    32'd0,         1,2, 1,32'd0,         8), // R8 geui
      mk(it(6'h18,1,2,16'hFFFF),  32'hFFFFFFFF, 32'd0,     1,2, 1,32'd0,         8), // R8 nei
      mk(it(6'h20,1,2,16'hFFFF),  32'hFFFFFFFF, 32'd0,     1,2, 1,32'd1,         8), // R8 eqi
      mk(rt(6'h13,1,2,3,0),  32'd1,         32'h00000023,  1,3, 1,32'd8,         9), // R9 sll low bits
      mk(rt(6'h3A,1,2,3,4),  32'h80000000,  32'd0,         1,3, 1,32'hF8000000,  9), // R9 srai
      mk(rt(6'h1B,1,2,3,0),  32'h80000000,  32'd31,        1,3, 1,32'd1,         9), // R9 srl
      mk(rt(6'h03,1,2,3,0),  32'h8000000F,  32'h00000024,  1,3, 1,32'h000000F8, 10), // R10 rol
      mk(rt(6'h0B,1,2,3,0),  32'h12345678,  32'd8,         1,3, 1,32'h78123456, 10), // R10 ror
      mk(rt(6'h02,1,2,3,0),  32'hDEADBEEF,  32'd9,         1,3, 1,32'hDEADBEEF, 10), // R10 roli 0
      mk(rt(6'h27,1,2,3,0),  32'h00010000,  32'h00010001,  1,3, 1,32'h00010000, 11), // R11 mul
      mk(rt(6'h07,1,2,3,0),  32'hFFFFFFFF,  32'hFFFFFFFF,  1,3, 1,32'hFFFFFFFE, 12), // R12 uu
      mk(rt(6'h1F,1,2,3,0),  32'hFFFFFFFF,  32'hFFFFFFFF,  1,3, 1,32'h00000000, 12), // R12 ss
      mk(rt(6'h17,1,2,3,0),  32'hFFFFFFFF,  32'hFFFFFFFF,  1,3, 1,32'hFFFFFFFF, 12), // R12 su
      mk(rt(6'h1F,1,2,3,0),  32'h80000000,  32'h80000000,  1,3, 1,32'h40000000, 12), // R12 ss min
      mk(rt(6'h31,0,2,3,0),  32'h00000055,  32'd3,         1,3, 1,32'd3,         2), // R2 A index 0
      mk(rt(6'h39,1,0,3,0),  32'd9,         32'd100,       1,3, 1,32'd9,         2), // R2 B index 0
      mk(rt(6'h31,1,2,0,0),  32'd1,         32'd1,         0,0, 0,32'd0,         3), // R3 dest 0
      mk(rt(6'h24,1,2,3,0),  32'd8,         32'd2,         0,3, 0,32'd0,         4), // R4 bad fn
      mk(it(6'h00,1,2,16'h0010), 32'd8,     32'd2,         0,2, 0,32'd0,         4)  // R4 bad op
   };

   logic        clk = 1'b0;
   logic [31:0] instr = '0, opa = '0, opb = '0;
   logic [31:0] result;
   logic [4:0]  dst;
   logic        wr_en;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   alu_int_exec uut (
      .instr  (instr),
      .opa    (opa),
      .opb    (opb),
      .result (result),
      .dst    (dst),
      .wr_en  (wr_en)
   );

   task automatic check(input bit ok, input int req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
      @(posedge clk);
      #1;
      instr = i; opa = a; opb = b;
      @(negedge clk);
   endtask

   initial begin
      // settle at time zero with an all-zero word: opcode 0x00 is not recognised (R4)
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(wr_en === 1'b0, 4, "idle wr_en", {31'd0, wr_en}, 32'd0);
      check(dst === 5'd0, 1, "idle dst", {27'd0, dst}, 32'd0);

      for (int k = 0; k < NV; k++) begin
         apply(VEC[k].ins, VEC[k].a, VEC[k].b);
         check(wr_en === VEC[k].wr, int'(VEC[k].req), $sformatf("vec %0d wr_en", k),
               {31'd0, wr_en}, {31'd0, VEC[k].wr});
         if (VEC[k].wr)
            check(dst === VEC[k].dst, int'(VEC[k].req), $sformatf("vec %0d dst", k),
                  {27'd0, dst}, {27'd0, VEC[k].dst});
         if (VEC[k].chk)
            check(result === VEC[k].res, int'(VEC[k].req), $sformatf("vec %0d result", k),
                  result, VEC[k].res);
      end

      // R10: rotate-left sweep over every register amount, upper bits of B set
      for (int s = 0; s < 32; s++) begin
         logic [31:0] a_v, exp_v;
         a_v   = 32'hC3A5_0F71;
         exp_v = (s == 0) ? a_v : ((a_v << s) | (a_v >> (32 - s)));
         apply(rt(6'h03, 1, 2, 3, 0), a_v, 32'hFFFF_FFE0 | 32'(s));
         check(result === exp_v, 10, $sformatf("rol sweep %0d", s), result, exp_v);
      end

      // R10: rotate-right sweep by immediate-free register form
      for (int s = 0; s < 32; s++) begin
         logic [31:0] a_v, exp_v;
         a_v   = 32'h8000_0001;
         exp_v = (s == 0) ? a_v : ((a_v >> s) | (a_v << (32 - s)));
         apply(rt(6'h0B, 1, 2, 3, 0), a_v, 32'(s));
         check(result === exp_v, 10, $sformatf("ror sweep %0d", s), result, exp_v);
      end

      // R9: shift-left immediate uses bits [10:6], ignoring B
      apply(rt(6'h12, 1, 2, 3, 5), 32'd3, 32'd1);
      check(result === 32'd96, 9, "slli amount field", result, 32'd96);

      // R3: index-0 destination with a compare still holds write enable low
      apply(it(6'h20, 1, 0, 16'd0), 32'd0, 32'd0);
      check(wr_en === 1'b0, 3, "cmpeqi to index 0", {31'd0, wr_en}, 32'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule